// File: doc/BRIEF.md
# Micro-op Expanding Fetch Group Builder

This block builds, each cycle, one group of up to `W` instruction slots for the decode stage. It walks an aligned cache block of fixed-size instructions from the current fetch PC. A plain instruction fills one slot. An instruction marked as a macro-op is expanded through a micro-op ROM lookup port, and each micro-op it returns fills one slot. Every slot asks a next-PC predictor port where control goes next. The group stops at a predicted redirect, at a quiesce instruction, at the last instruction of the block, or when all `W` slots are full. A 3-bit code reports why the group ended.

The fetch PC, the micro-PC of an expansion that is still in progress, and a sequence counter are kept in registers. An expansion that runs out of slots therefore resumes at its next micro-op in the following group. The cache block, the ROM and the predictor sit outside the block, and their responses are combinational in the same cycle.

The group leaves on a valid/ready stream. `grp_valid` is high whenever a cache block is present (`blk_valid`) and no quiesce is pending. The group is accepted on a cycle with both `grp_valid` and `grp_ready` high, and only then does internal state advance. While `grp_ready` is low, state holds, so the same group is offered again as long as the inputs hold. Nothing requires `grp_valid` to wait for `grp_ready`.

Top module: `fgb_group_builder`

## Requirements
- R1: Synchronous reset puts the fetch PC at `RESET_PC` (0), clears quiesce-pending, sets the sequence counter to 0, and leaves no expansion in progress.
- R2: Slots fill in program order from slot 0. `slot_valid` is a contiguous run from bit 0, and `grp_count` (0..W) equals its population. A plain instruction gives a slot with the fetched word as op, its PC, and micro-PC 0.
- R3: A macro-op fills consecutive slots with the ROM result for micro-PC 0, 1, 2 and so on. The expansion ends with the op that the ROM flags as last, and the following instruction is then taken at PC+INST_BYTES.
- R4: When the slots run out during an expansion, the next accepted group starts with the same PC at the next micro-PC.
- R5: Slot i carries sequence number base+i. The base advances by `grp_count` on each accepted group.
- R6: The predictor is consulted for every slot. The slot's predicted next PC and next micro-PC follow three rules. A taken prediction gives the target and micro-PC 0. A non-last micro-op gives the same PC and micro-PC+1. Any other op gives PC+INST_BYTES and micro-PC 0. A taken slot ends the group, drops any expansion in progress, and the next group starts at the target.
- R7: An op that completes the last instruction of the cache block ends the group.
- R8: A plain instruction flagged as quiesce is emitted in its slot and ends the group. `qsc_enter` is high with that group, and `qsc_pending` is set from the next cycle on.
- R9: `grp_reason` encodes 0 = no group, 1 = predicted redirect, 2 = width full, 3 = block end, 4 = quiesce, chosen in that priority (1 over 2 over 3 over 4).
- R10: While `grp_valid` is high and `grp_ready` is low, the fetch PC, the sequence base and the pending state do not change.
- R11: `grp_valid` is high exactly when `blk_valid` is high and no quiesce is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_valid | input | 1 | Cache block for the fetch PC is present |
| blk_ops | input | BLK_INSTS*OPW | Instruction words of the block, word j at bits j*OPW |
| blk_macro | input | BLK_INSTS | Pre-decode: word j is a macro-op |
| blk_qsc | input | BLK_INSTS | Pre-decode: word j is a quiesce instruction |
| fetch_pc | output | PCW | Current fetch PC; the block supplied must contain it |
| rom_op | output | W*OPW | Per slot: macro-op word for the ROM lookup |
| rom_upc | output | W*UPCW | Per slot: micro-PC for the ROM lookup |
| rom_uop | input | W*OPW | Per slot: micro-op returned by the ROM |
| rom_last | input | W | Per slot: returned micro-op is the last one |
| pred_pc | output | W*PCW | Per slot: PC presented to the predictor |
| pred_taken | input | W | Per slot: predictor redirects |
| pred_target | input | W*PCW | Per slot: redirect target |
| grp_valid | output | 1 | Group offered |
| grp_ready | input | 1 | Decode accepts the group |
| slot_valid | output | W | Slot holds an op |
| slot_op | output | W*OPW | Op per slot |
| slot_pc | output | W*PCW | PC per slot |
| slot_upc | output | W*UPCW | Micro-PC per slot |
| slot_npc | output | W*PCW | Predicted next PC per slot |
| slot_nupc | output | W*UPCW | Predicted next micro-PC per slot |
| slot_seq | output | W*SEQW | Sequence number per slot |
| grp_count | output | $clog2(W+1) | Number of valid slots |
| grp_reason | output | 3 | Termination reason code |
| qsc_pending | output | 1 | Quiesce pending; fetch halted |
| qsc_enter | output | 1 | Accepted group contains a quiesce |

## Verification
A wrong internal state shows up at the slot outputs of the very next accepted group. A bad fetch-PC register gives wrong `slot_pc` and op values. A lost or corrupted micro-PC makes a resumed expansion restart at micro-op 0 or skip one. A sequence counter that slips breaks the base+i chain across groups. A stuck quiesce flag either keeps `grp_valid` low or fails to halt fetch after a quiesce. The scoreboard compares every field of every accepted group against a separate step-by-step model, so each of these faults is caught within one group of its cause.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
  typedef enum logic [2:0] {
    RSN_IDLE    = 3'd0,
    RSN_BRANCH  = 3'd1,
    RSN_WIDTH   = 3'd2,
    RSN_BLKEND  = 3'd3,
    RSN_QUIESCE = 3'd4
  } fgb_reason_e;
endpackage

// File: rtl/fgb_slot.sv
// One slot of the group: selects the word at the current offset, expands it
// through the ROM port when it is a macro-op, and steps the PC chain.
module fgb_slot #(
  parameter int BLK_INSTS  = 8,
  parameter int INST_BYTES = 4,
  parameter int PCW        = 32,
  parameter int OPW        = 16,
  parameter int UPCW       = 4
) (
  input  logic [PCW-1:0]           cur_pc,
  input  logic [UPCW-1:0]          cur_upc,
  input  logic                     cur_mac,
  input  logic                     live_in,
  input  logic [BLK_INSTS*OPW-1:0] blk_ops,
  input  logic [BLK_INSTS-1:0]     blk_macro,
  input  logic [BLK_INSTS-1:0]     blk_qsc,
  output logic [OPW-1:0]           rom_op,
  output logic [UPCW-1:0]          rom_upc,
  input  logic [OPW-1:0]           rom_uop,
  input  logic                     rom_last,
  output logic [PCW-1:0]           pred_pc,
  input  logic                     pred_taken,
  input  logic [PCW-1:0]           pred_target,
  output logic [OPW-1:0]           op,
  output logic [PCW-1:0]           step_pc,
  output logic [UPCW-1:0]          step_upc,
  output logic [PCW-1:0]           nxt_pc,
  output logic [UPCW-1:0]          nxt_upc,
  output logic                     nxt_mac,
  output logic                     live_out,
  output logic                     hit_taken,
  output logic                     hit_qsc,
  output logic                     hit_blkend
);
  localparam int IB   = $clog2(INST_BYTES);
  localparam int OFFW = (BLK_INSTS > 1) ? $clog2(BLK_INSTS) : 1;

  logic [OFFW-1:0] off;
  logic [OPW-1:0]  raw;
  logic            is_mac, is_last, at_end, step_mac;

  assign off     = cur_pc[IB +: OFFW];
  assign raw     = blk_ops[off*OPW +: OPW];
  assign is_mac  = cur_mac | blk_macro[off];
  assign is_last = is_mac ? rom_last : 1'b1;
  assign at_end  = (off == OFFW'(BLK_INSTS-1));

  assign rom_op  = raw;
  assign rom_upc = cur_upc;
  assign pred_pc = cur_pc;
  assign op      = is_mac ? rom_uop : raw;

  always_comb begin
    if (pred_taken) begin
      step_pc  = pred_target;
      step_upc = '0;
      step_mac = 1'b0;
    end else if (!is_last) begin
      step_pc  = cur_pc;
      step_upc = cur_upc + UPCW'(1);
      step_mac = 1'b1;
    end else begin
      step_pc  = cur_pc + PCW'(INST_BYTES);
      step_upc = '0;
      step_mac = 1'b0;
    end
  end

  assign hit_taken  = live_in & pred_taken;
  assign hit_qsc    = live_in & ~is_mac & blk_qsc[off];
  assign hit_blkend = live_in & ~pred_taken & is_last & at_end;
  assign live_out   = live_in & ~hit_taken & ~hit_qsc & ~hit_blkend;

  assign nxt_pc  = live_in ? step_pc  : cur_pc;
  assign nxt_upc = live_in ? step_upc : cur_upc;
  assign nxt_mac = live_in ? step_mac : cur_mac;
endmodule

// File: rtl/fgb_state.sv
// Fetch state carried between groups; advances only on an accepted group.
module fgb_state #(
  parameter int PCW      = 32,
  parameter int UPCW     = 4,
  parameter int SEQW     = 16,
  parameter int CW       = 3,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [PCW-1:0]  nxt_pc,
  input  logic [UPCW-1:0] nxt_upc,
  input  logic            nxt_mac,
  input  logic [CW-1:0]   seq_add,
  input  logic            enter_qsc,
  output logic [PCW-1:0]  st_pc,
  output logic [UPCW-1:0] st_upc,
  output logic            st_mac,
  output logic [SEQW-1:0] st_seq,
  output logic            st_qsc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_pc  <= PCW'(RESET_PC);
      st_upc <= '0;
      st_mac <= 1'b0;
      st_seq <= '0;
      st_qsc <= 1'b0;
    end else if (fire) begin
      st_pc  <= nxt_pc;
      st_upc <= nxt_upc;
      st_mac <= nxt_mac;
      st_seq <= st_seq + SEQW'(seq_add);
      st_qsc <= enter_qsc;
    end
  end
endmodule

// File: rtl/fgb_group_builder.sv
module fgb_group_builder
  import fgb_pkg::*;
#(
  parameter int W          = 4,
  parameter int BLK_INSTS  = 8,
  parameter int INST_BYTES = 4,
  parameter int PCW        = 32,
  parameter int OPW        = 16,
  parameter int UPCW       = 4,
  parameter int SEQW       = 16,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int CW        = $clog2(W+1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     blk_valid,
  input  logic [BLK_INSTS*OPW-1:0] blk_ops,
  input  logic [BLK_INSTS-1:0]     blk_macro,
  input  logic [BLK_INSTS-1:0]     blk_qsc,
  output logic [PCW-1:0]           fetch_pc,
  output logic [W*OPW-1:0]         rom_op,
  output logic [W*UPCW-1:0]        rom_upc,
  input  logic [W*OPW-1:0]         rom_uop,
  input  logic [W-1:0]             rom_last,
  output logic [W*PCW-1:0]         pred_pc,
  input  logic [W-1:0]             pred_taken,
  input  logic [W*PCW-1:0]         pred_target,
  output logic                     grp_valid,
  input  logic                     grp_ready,
  output logic [W-1:0]             slot_valid,
  output logic [W*OPW-1:0]         slot_op,
  output logic [W*PCW-1:0]         slot_pc,
  output logic [W*UPCW-1:0]        slot_upc,
  output logic [W*PCW-1:0]         slot_npc,
  output logic [W*UPCW-1:0]        slot_nupc,
  output logic [W*SEQW-1:0]        slot_seq,
  output logic [CW-1:0]            grp_count,
  output logic [2:0]               grp_reason,
  output logic                     qsc_pending,
  output logic                     qsc_enter
);
  logic [PCW-1:0]  st_pc;
  logic [UPCW-1:0] st_upc;
  logic            st_mac;
  logic [SEQW-1:0] st_seq;
  logic            fire;

  logic [PCW-1:0]  c_pc   [W+1];
  logic [UPCW-1:0] c_upc  [W+1];
  logic            c_mac  [W+1];
  logic            c_live [W+1];
  logic [W-1:0]    tk_v, qs_v, be_v;

  assign grp_valid = blk_valid & ~qsc_pending;
  assign fire      = grp_valid & grp_ready;
  assign fetch_pc  = st_pc;

  assign c_pc[0]   = st_pc;
  assign c_upc[0]  = st_upc;
  assign c_mac[0]  = st_mac;
  assign c_live[0] = grp_valid;

  for (genvar g = 0; g < W; g++) begin : g_slot
    fgb_slot #(
      .BLK_INSTS(BLK_INSTS), .INST_BYTES(INST_BYTES),
      .PCW(PCW), .OPW(OPW), .UPCW(UPCW)
    ) u_slot (
      .cur_pc     (c_pc[g]),
      .cur_upc    (c_upc[g]),
      .cur_mac    (c_mac[g]),
      .live_in    (c_live[g]),
      .blk_ops    (blk_ops),
      .blk_macro  (blk_macro),
      .blk_qsc    (blk_qsc),
      .rom_op     (rom_op[g*OPW +: OPW]),
      .rom_upc    (rom_upc[g*UPCW +: UPCW]),
      .rom_uop    (rom_uop[g*OPW +: OPW]),
      .rom_last   (rom_last[g]),
      .pred_pc    (pred_pc[g*PCW +: PCW]),
      .pred_taken (pred_taken[g]),
      .pred_target(pred_target[g*PCW +: PCW]),
      .op         (slot_op[g*OPW +: OPW]),
      .step_pc    (slot_npc[g*PCW +: PCW]),
      .step_upc   (slot_nupc[g*UPCW +: UPCW]),
      .nxt_pc     (c_pc[g+1]),
      .nxt_upc    (c_upc[g+1]),
      .nxt_mac    (c_mac[g+1]),
      .live_out   (c_live[g+1]),
      .hit_taken  (tk_v[g]),
      .hit_qsc    (qs_v[g]),
      .hit_blkend (be_v[g])
    );
    assign slot_valid[g]             = c_live[g];
    assign slot_pc[g*PCW +: PCW]     = c_pc[g];
    assign slot_upc[g*UPCW +: UPCW]  = c_upc[g];
    assign slot_seq[g*SEQW +: SEQW]  = st_seq + SEQW'(g);
  end

  always_comb begin
    grp_count = '0;
    for (int i = 0; i < W; i++) grp_count = grp_count + CW'(slot_valid[i]);
  end

  always_comb begin
    if (!grp_valid)            grp_reason = RSN_IDLE;
    else if (|tk_v)            grp_reason = RSN_BRANCH;
    else if (grp_count == CW'(W)) grp_reason = RSN_WIDTH;
    else if (|be_v)            grp_reason = RSN_BLKEND;
    else if (|qs_v)            grp_reason = RSN_QUIESCE;
    else                       grp_reason = RSN_IDLE;
  end

  assign qsc_enter = fire & (|qs_v);

  fgb_state #(
    .PCW(PCW), .UPCW(UPCW), .SEQW(SEQW), .CW(CW), .RESET_PC(RESET_PC)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .nxt_pc   (c_pc[W]),
    .nxt_upc  (c_upc[W]),
    .nxt_mac  (c_mac[W]),
    .seq_add  (grp_count),
    .enter_qsc(|qs_v),
    .st_pc    (st_pc),
    .st_upc   (st_upc),
    .st_mac   (st_mac),
    .st_seq   (st_seq),
    .st_qsc   (qsc_pending)
  );
endmodule

// File: rtl/fgb_checker.sv
module fgb_checker #(
  parameter int W    = 4,
  parameter int PCW  = 32,
  parameter int SEQW = 16,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            blk_valid,
  input logic            grp_valid,
  input logic            grp_ready,
  input logic [W-1:0]    slot_valid,
  input logic [CW-1:0]   grp_count,
  input logic [2:0]      grp_reason,
  input logic [PCW-1:0]  fetch_pc,
  input logic [SEQW-1:0] seq_base,
  input logic            qsc_pending,
  input logic            qsc_enter
);
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    grp_count <= CW'(W)); // R2
  AST_SLOT0_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|slot_valid) |-> slot_valid[0]); // R2
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && grp_ready) |=> seq_base == $past(seq_base) + SEQW'($past(grp_count))); // R5
  AST_FULL_REASON: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && grp_count == CW'(W)) |-> (grp_reason == 3'd1 || grp_reason == 3'd2)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !grp_ready) |=> ($stable(fetch_pc) && $stable(seq_base))); // R10
  AST_QSC_LATCH: assert property (@(posedge clk) disable iff (rst)
    qsc_enter |=> qsc_pending); // R8
  AST_QSC_HALT: assert property (@(posedge clk) disable iff (rst)
    qsc_pending |-> !grp_valid); // R11
  AST_NO_BLOCK: assert property (@(posedge clk) disable iff (rst)
    !blk_valid |-> (grp_reason == 3'd0 && slot_valid == '0)); // R11
endmodule

bind fgb_group_builder fgb_checker #(
  .W(W), .PCW(PCW), .SEQW(SEQW), .CW(CW)
) u_fgb_checker (
  .clk        (clk),
  .rst        (rst),
  .blk_valid  (blk_valid),
  .grp_valid  (grp_valid),
  .grp_ready  (grp_ready),
  .slot_valid (slot_valid),
  .grp_count  (grp_count),
  .grp_reason (grp_reason),
  .fetch_pc   (fetch_pc),
  .seq_base   (slot_seq[SEQW-1:0]),
  .qsc_pending(qsc_pending),
  .qsc_enter  (qsc_enter)
);

// File: tb/test_fgb_group_builder.sv
module test_fgb_group_builder;
  localparam int W = 4, BLK = 8, PCW = 32, OPW = 16, UPCW = 4, SEQW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                 blk_valid = 1'b0;
  logic [BLK*OPW-1:0]   blk_ops;
  logic [BLK-1:0]       blk_macro, blk_qsc;
  logic [PCW-1:0]       fetch_pc;
  logic [W*OPW-1:0]     rom_op, rom_uop;
  logic [W*UPCW-1:0]    rom_upc;
  logic [W-1:0]         rom_last, pred_taken;
  logic [W*PCW-1:0]     pred_pc, pred_target;
  logic                 grp_valid, grp_ready = 1'b0;
  logic [W-1:0]         slot_valid;
  logic [W*OPW-1:0]     slot_op;
  logic [W*PCW-1:0]     slot_pc, slot_npc;
  logic [W*UPCW-1:0]    slot_upc, slot_nupc;
  logic [W*SEQW-1:0]    slot_seq;
  logic [2:0]           grp_count, grp_reason;
  logic                 qsc_pending, qsc_enter;

  fgb_group_builder i_fgb_group_builder (.*);

  // Program image: word k at PC 4k is 16'h1000+k.
  logic [63:0] mac_m, qsc_m, tk_m;
  logic [31:0] tgt_m [64];

  always_comb begin
    for (int j = 0; j < BLK; j++) begin
      automatic logic [5:0] k = {fetch_pc[7:5], 3'(j)};
      blk_ops[j*OPW +: OPW] = 16'h1000 + 16'(k);
      blk_macro[j] = mac_m[k];
      blk_qsc[j]   = qsc_m[k];
    end
    for (int i = 0; i < W; i++) begin
      automatic logic [15:0] o = rom_op[i*OPW +: OPW];
      automatic logic [3:0]  u = rom_upc[i*UPCW +: UPCW];
      automatic logic [5:0]  pk = pred_pc[i*PCW+2 +: 6];
      rom_uop[i*OPW +: OPW] = {4'hA, o[7:0], u};
      rom_last[i] = (u == {2'b00, o[1:0]});
      pred_taken[i] = tk_m[pk];
      pred_target[i*PCW +: PCW] = tgt_m[pk];
    end
  end

  typedef struct {
    int          cnt;
    int          rsn;
    bit          qs;
    logic [15:0] op  [W];
    logic [31:0] pc  [W];
    logic [3:0]  upc [W];
    logic [31:0] npc [W];
    logic [3:0]  nupc[W];
    logic [15:0] seq [W];
  } grp_t;

  grp_t exp_q[$];
  int checks = 0, fails = 0;
  int last_cnt, last_rsn, last_upc0;

  logic [31:0] m_pc;
  logic [3:0]  m_upc;
  bit          m_mac;
  logic [15:0] m_seq;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: build the expected group from the model and push it.
  task automatic push_group();
    grp_t e;
    bit stop = 0, br = 0, be = 0;
    e.cnt = 0; e.qs = 0;
    for (int i = 0; i < W; i++) begin
      logic [5:0] k; logic [15:0] raw; bit ism, last, tk, q;
      logic [31:0] np; logic [3:0] nu; bit nm;
      if (stop) break;
      k = m_pc[7:2]; raw = 16'h1000 + 16'(k);
      ism = m_mac || mac_m[k];
      last = ism ? (m_upc == {2'b00, raw[1:0]}) : 1'b1;
      tk = tk_m[k]; q = !ism && qsc_m[k];
      if (tk) begin np = tgt_m[k]; nu = 0; nm = 0; end
      else if (!last) begin np = m_pc; nu = m_upc + 1; nm = 1; end
      else begin np = m_pc + 4; nu = 0; nm = 0; end
      e.op[i]  = ism ? {4'hA, raw[7:0], m_upc} : raw;
      e.pc[i]  = m_pc; e.upc[i] = m_upc;
      e.npc[i] = np;   e.nupc[i] = nu;
      e.seq[i] = m_seq;
      e.cnt++; m_seq++;
      m_pc = np; m_upc = nu; m_mac = nm;
      if (tk) br = 1;
      if (q) e.qs = 1;
      if (!tk && last && k[2:0] == 3'd7) be = 1;
      stop = tk || q || (!tk && last && k[2:0] == 3'd7);
    end
    e.rsn = br ? 1 : (e.cnt == W) ? 2 : be ? 3 : e.qs ? 4 : 0;
    exp_q.push_back(e);
  endtask

  // Monitor: compare each accepted group with the queue head.
  always @(negedge clk) begin
    if (!rst && grp_valid && grp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected group actual=%0d expected=none", grp_count);
      end else begin
        automatic grp_t e = exp_q.pop_front();
        chk("R2", "count", grp_count, e.cnt);
        chk("R9", "reason", grp_reason, e.rsn);
        chk("R8", "qsc_enter", qsc_enter, e.qs);
        for (int i = 0; i < W; i++) begin
          if (i < e.cnt) begin
            chk("R2", "slot_valid", slot_valid[i], 1);
            chk("R3", "op",   slot_op[i*OPW +: OPW], e.op[i]);
            chk("R2", "pc",   slot_pc[i*PCW +: PCW], e.pc[i]);
            chk("R3", "upc",  slot_upc[i*UPCW +: UPCW], e.upc[i]);
            chk("R6", "npc",  slot_npc[i*PCW +: PCW], e.npc[i]);
            chk("R6", "nupc", slot_nupc[i*UPCW +: UPCW], e.nupc[i]);
            chk("R5", "seq",  slot_seq[i*SEQW +: SEQW], e.seq[i]);
          end else begin
            chk("R2", "slot_valid", slot_valid[i], 0);
          end
        end
        last_cnt = grp_count; last_rsn = grp_reason;
        last_upc0 = slot_upc[UPCW-1:0];
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1; grp_ready = 1'b0; blk_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    m_pc = 0; m_upc = 0; m_mac = 0; m_seq = 0;
    @(negedge clk);
    chk("R1", "fetch_pc", fetch_pc, 0);
    chk("R1", "qsc_pending", qsc_pending, 0);
    chk("R1", "seq base", slot_seq[SEQW-1:0], 0);
    chk("R1", "upc", slot_upc[UPCW-1:0], 0);
  endtask

  task automatic one_group();
    @(posedge clk); #1;
    push_group();
    grp_ready = 1'b1;
    @(negedge clk); #1;
    @(posedge clk); #1;
    grp_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_prog();
    mac_m = '0; qsc_m = '0; tk_m = '0;
    for (int k = 0; k < 64; k++) tgt_m[k] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_prog();
    // Scenario A: plain stream; second group both fills width and hits block end.
    do_reset();
    one_group();
    one_group();
    chk("R9", "width over block end", last_rsn, 2);
    one_group();
    blk_valid = 1'b0;
    @(negedge clk);
    chk("R11", "no block -> no group", grp_valid, 0);
    blk_valid = 1'b1;

    // Scenario B: macro-ops, expansion cut by width and resumed.
    clear_prog();
    mac_m[2] = 1'b1; mac_m[5] = 1'b1;
    do_reset();
    one_group();
    one_group();
    chk("R4", "resume micro-PC", last_upc0, 2);
    one_group();
    chk("R7", "block end count", last_cnt, 3);
    chk("R7", "block end reason", last_rsn, 3);

    // Stall: state holds while ready is low.
    begin
      automatic logic [31:0] p0 = fetch_pc;
      automatic logic [15:0] s0 = slot_seq[SEQW-1:0];
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R10", "pc held", fetch_pc, p0);
      chk("R10", "seq held", slot_seq[SEQW-1:0], s0);
    end

    // Scenario C: redirects, including branch over width priority.
    clear_prog();
    tk_m[1] = 1'b1; tgt_m[1] = 52;
    tk_m[19] = 1'b1; tgt_m[19] = 0;
    mac_m[9] = 1'b1;
    do_reset();
    one_group();
    chk("R6", "taken reason", last_rsn, 1);
    chk("R6", "taken count", last_cnt, 2);
    chk("R6", "target pc", fetch_pc, 52);
    one_group();
    one_group();
    chk("R9", "branch over width", last_rsn, 1);
    one_group();

    // Scenario D: quiesce halts fetch.
    clear_prog();
    qsc_m[2] = 1'b1;
    do_reset();
    one_group();
    chk("R8", "quiesce count", last_cnt, 3);
    chk("R8", "quiesce pending", qsc_pending, 1);
    chk("R11", "halted", grp_valid, 0);
    grp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    grp_ready = 1'b0;
    chk("R8", "still pending", qsc_pending, 1);

    chk("R2", "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule